// File: doc/BRIEF.md
# Multicycle Word-Addressed Load/Store Core

This block is a small 32-bit processor. It runs each instruction as a fixed series of register-transfer steps, one step per clock. A single memory port serves both instruction fetch and data access. Memory is word addressed. The read path answers within the step that presents the address, and a write lands at the clock edge that closes the store's final step. Internally the core holds an instruction register, a program counter, operand latches A and B, a result latch C, a memory address latch and a memory data latch. It also has a 32-entry register file whose entry 0 is hard-wired to zero.

The core has no dedicated subtractor and no comparator. The one adder subtracts by adding the inverted, sign-extended immediate plus one. The greater-than test looks at the sign bit of that difference, checks it for zero, and then forms the 0/1 flag from a value fetched out of register 0. The core reports the current step number and pulses a retire signal in the last step of every completed instruction, so the cycle cost of each instruction can be observed.

Controller states: FETCH, DECODE, ADDR, MEMRD, STMDR, MEMWR, EXEC, ZERO, FLAG, WB. The transitions are:
- FETCH goes to DECODE.
- DECODE goes to ADDR for a load or a store, to EXEC for AND, subtract or compare, and back to FETCH for any other opcode.
- ADDR goes to MEMRD for a load and to STMDR for a store.
- MEMRD goes to WB.
- STMDR goes to MEMWR, and MEMWR goes to FETCH.
- EXEC goes to ZERO for a compare and to WB otherwise.
- ZERO goes to FLAG, FLAG goes to WB, and WB goes to FETCH.

Top module: `mc_core`

## Requirements
- R1: While reset is held, step is 0, mem_addr is 0 (the program counter clears), mem_we is 0 and retire is 0. The first fetch after reset reads word 0.
- R2: Load (opcode 0x23 in bits 31:26, base register in 25:21, target in 20:16, immediate in 15:0) writes memory[base + sign-extended immediate] into the target. It takes 5 cycles.
- R3: Store (opcode 0x2B, base in 25:21, data register in 20:16, immediate in 15:0) writes the data register to memory[base + sign-extended immediate]. It takes 5 cycles, and mem_we is high only in its last step.
- R4: AND (opcode 0x24, first source in 25:21, target in 20:16, second source in 15:11) writes the bitwise AND of the two sources. It takes 4 cycles.
- R5: Subtract-immediate (opcode 0x0A, source in 25:21, target in 20:16) writes source minus the sign-extended immediate, modulo 2^32. It takes 4 cycles.
- R6: Compare-immediate (opcode 0x0B) forms D = source − sign-extended immediate (modulo 2^32). It writes 1 when bit 31 of D is 0 and D is nonzero, and writes 0 otherwise. Bits 31:1 of the result are always 0. It takes 6 cycles.
- R7: Register 0 reads as zero, and a write aimed at it is discarded. A base of register 0 therefore addresses memory absolutely through the immediate.
- R8: An unknown opcode uses 2 cycles (fetch and decode). It does not retire, writes no register and no memory, and execution continues at the next word.
- R9: step is 0 in the fetch step and rises by one each cycle. retire is high for exactly the final step of each completed instruction, and that step is one less than the instruction's cycle count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | AW | Word address: program counter in fetch, address latch in data steps |
| mem_wdata | output | DW | Store data from the memory data latch |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | DW | Memory read data, valid within the addressing step |
| step | output | 3 | Step index inside the current instruction |
| retire | output | 1 | High in the final step of a completed instruction |

## Verification
After reset is released, the core is in its fetch step, and the n-th negative clock edge after release shows step n. An instruction of length L therefore retires at the edge L−1 cycles after its own fetch edge. The bench samples step and retire on every negative edge. It checks that the gap between two retires equals the length of the later instruction, which is 6 when a 2-cycle unknown opcode sits in between. Register results become visible through stores. A store's write reaches memory at the edge that closes its retire step, so memory is inspected one full cycle after the last retire.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_AND   = 6'h24;
    localparam logic [5:0] OP_SUBI  = 6'h0A;
    localparam logic [5:0] OP_SGTI  = 6'h0B;

    typedef enum logic [3:0] {
        ST_FETCH, ST_DECODE, ST_ADDR, ST_MEMRD, ST_STMDR,
        ST_MEMWR, ST_EXEC, ST_ZERO, ST_FLAG, ST_WB
    } state_t;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_AND
    } alu_op_t;

    typedef struct packed {
        logic    ir_ld;
        logic    pc_inc;
        logic    ab_ld;
        logic    a_from_r0;
        logic    mar_ld;
        logic    c_from_alu;
        logic    c_from_mem;
        logic    c_from_flag;
        logic    mdr_ld;
        logic    mem_we;
        logic    addr_mar;
        logic    rf_we;
        alu_op_t alu_op;
    } ctrl_t;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
    import mc_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic [DW-1:0] opa,
    input  logic [DW-1:0] opb,
    input  logic [DW-1:0] imm,
    input  alu_op_t       op,
    output logic [DW-1:0] res
);

    always_comb begin
        unique case (op)
            ALU_ADD: res = opa + imm;
            ALU_SUB: res = opa + ~imm + {{(DW-1){1'b0}}, 1'b1};
            ALU_AND: res = opa & opb;
            default: res = opa + imm;
        endcase
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile #(
    parameter int DW   = 32,
    parameter int NREG = 32,
    localparam int RW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ra0,
    input  logic [RW-1:0] ra1,
    output logic [DW-1:0] rd0,
    output logic [DW-1:0] rd1,
    input  logic          we,
    input  logic [RW-1:0] wa,
    input  logic [DW-1:0] wd
);

    logic [DW-1:0] regs [NREG];

    assign regs[0] = '0;

    for (genvar g = 1; g < NREG; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && wa == RW'(g))
                regs[g] <= wd;
        end
    end

    assign rd0 = regs[ra0];
    assign rd1 = regs[ra1];

    // R7: entry zero answers zero even right after a write aimed at it
    a_r7_zero_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ra0 == '0) |-> (rd0 == '0));
    a_r7_zero_write_lost: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wa == '0) |=> (regs[0] == '0));

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
    import mc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    output ctrl_t      ctl,
    output logic [2:0] step,
    output logic       retire
);

    state_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            step  <= '0;
        end else begin
            state <= nxt;
            step  <= (nxt == ST_FETCH) ? 3'd0 : step + 3'd1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                if (opcode == OP_LOAD || opcode == OP_STORE)
                    nxt = ST_ADDR;
                else if (opcode == OP_AND || opcode == OP_SUBI || opcode == OP_SGTI)
                    nxt = ST_EXEC;
                else
                    nxt = ST_FETCH;
            end
            ST_ADDR:   nxt = (opcode == OP_LOAD) ? ST_MEMRD : ST_STMDR;
            ST_MEMRD:  nxt = ST_WB;
            ST_STMDR:  nxt = ST_MEMWR;
            ST_MEMWR:  nxt = ST_FETCH;
            ST_EXEC:   nxt = (opcode == OP_SGTI) ? ST_ZERO : ST_WB;
            ST_ZERO:   nxt = ST_FLAG;
            ST_FLAG:   nxt = ST_WB;
            ST_WB:     nxt = ST_FETCH;
            default:   nxt = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl        = '0;
        ctl.alu_op = ALU_ADD;
        retire     = 1'b0;
        unique case (state)
            ST_FETCH:  ctl.ir_ld = 1'b1;
            ST_DECODE: begin
                ctl.pc_inc = 1'b1;
                ctl.ab_ld  = 1'b1;
            end
            ST_ADDR:   ctl.mar_ld = 1'b1;
            ST_MEMRD: begin
                ctl.addr_mar   = 1'b1;
                ctl.c_from_mem = 1'b1;
            end
            ST_STMDR:  ctl.mdr_ld = 1'b1;
            ST_MEMWR: begin
                ctl.addr_mar = 1'b1;
                ctl.mem_we   = 1'b1;
                retire       = 1'b1;
            end
            ST_EXEC: begin
                ctl.c_from_alu = 1'b1;
                ctl.alu_op     = (opcode == OP_AND) ? ALU_AND : ALU_SUB;
            end
            ST_ZERO:   ctl.a_from_r0   = 1'b1;
            ST_FLAG:   ctl.c_from_flag = 1'b1;
            ST_WB: begin
                ctl.rf_we = 1'b1;
                retire    = 1'b1;
            end
            default: ;
        endcase
    end

    // R9: the fetch step is always numbered zero
    a_r9_fetch_is_step0: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |-> (step == 3'd0));
    // R9: a retire is followed by a fresh fetch
    a_r9_retire_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> (step == 3'd0));
    // R8: the decode step never completes an instruction
    a_r8_decode_no_retire: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 3'd1) |-> !retire);
    // R6: the sixth step exists only as the compare write-back
    a_r6_six_step_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 3'd5) |-> (retire && opcode == OP_SGTI));

endmodule

// File: rtl/mc_core.sv
module mc_core
    import mc_pkg::*;
#(
    parameter int DW   = 32,
    parameter int AW   = 16,
    parameter int NREG = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata,
    output logic [2:0]    step,
    output logic          retire
);

    localparam int RW = $clog2(NREG);
    localparam int IW = 16;

    logic [DW-1:0] ir, a_q, b_q, c_q, mdr;
    logic [AW-1:0] pc, mar;
    ctrl_t         ctl;

    logic [5:0]    opcode;
    logic [RW-1:0] f_rs1, f_rd, f_rs2, ra0, ra1;
    logic [DW-1:0] imm_x, rd0, rd1, alu_y, flag_val;

    assign opcode = ir[31:26];
    assign f_rs1  = ir[25:21];
    assign f_rd   = ir[20:16];
    assign f_rs2  = ir[15:11];
    assign imm_x  = {{(DW-IW){ir[IW-1]}}, ir[IW-1:0]};

    assign ra0 = ctl.a_from_r0 ? '0 : f_rs1;
    assign ra1 = (opcode == OP_STORE) ? f_rd : f_rs2;

    mc_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .opcode (opcode),
        .ctl    (ctl),
        .step   (step),
        .retire (retire)
    );

    mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra0   (ra0),
        .ra1   (ra1),
        .rd0   (rd0),
        .rd1   (rd1),
        .we    (ctl.rf_we),
        .wa    (f_rd),
        .wd    (c_q)
    );

    mc_alu #(.DW(DW)) u_alu (
        .opa (a_q),
        .opb (b_q),
        .imm (imm_x),
        .op  (ctl.alu_op),
        .res (alu_y)
    );

    // sign bit clear and difference nonzero: take complement of A (A holds zero)
    assign flag_val = (c_q[DW-1] || c_q == '0) ? a_q
                                              : {{(DW-1){1'b0}}, ~a_q[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir  <= '0;
            pc  <= '0;
            a_q <= '0;
            b_q <= '0;
            c_q <= '0;
            mar <= '0;
            mdr <= '0;
        end else begin
            if (ctl.ir_ld)       ir  <= mem_rdata;
            if (ctl.pc_inc)      pc  <= pc + AW'(1);
            if (ctl.ab_ld)       a_q <= rd0;
            if (ctl.a_from_r0)   a_q <= rd0;
            if (ctl.ab_ld)       b_q <= rd1;
            if (ctl.mar_ld)      mar <= alu_y[AW-1:0];
            if (ctl.mdr_ld)      mdr <= b_q;
            if (ctl.c_from_alu)  c_q <= alu_y;
            if (ctl.c_from_mem)  c_q <= mem_rdata;
            if (ctl.c_from_flag) c_q <= flag_val;
        end
    end

    assign mem_addr  = ctl.addr_mar ? mar : pc;
    assign mem_wdata = mdr;
    assign mem_we    = ctl.mem_we;

    // R3: memory is written only in the retiring step of a store
    a_r3_write_at_retire: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (retire && opcode == OP_STORE));
    // R6: a compare write-back carries a clean 0/1 value
    a_r6_flag_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && opcode == OP_SGTI) |-> (c_q[DW-1:1] == '0));
    // R8: an unknown opcode leaves memory untouched and moves to the next word
    a_r8_unknown_skips: assert property (@(posedge clk) disable iff (!rst_n)
        (step == 3'd1 && opcode != OP_LOAD && opcode != OP_STORE &&
         opcode != OP_AND && opcode != OP_SUBI && opcode != OP_SGTI)
        |=> (step == 3'd0 && !mem_we && mem_addr == $past(pc) + AW'(1)));

endmodule

// File: tb/mc_core_test.sv
module mc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic [31:0] mem_rdata;
    logic [2:0]  step;
    logic        retire;

    logic [31:0] mem [256];
    int checks = 0;
    int fails  = 0;
    int total_cyc = 0;

    always #10 clk = ~clk;

    mc_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .step      (step),
        .retire    (retire)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(posedge clk) begin
        total_cyc <= total_cyc + 1;
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    end

    always @(posedge clk) begin
        if (total_cyc > 150000) begin
            $display("FAIL watchdog: actual %0d cycles expected < 150000", total_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", checks + 1, fails + 1);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] s,
                                        input logic [4:0] d, input logic [15:0] im);
        return {op, s, d, im};
    endfunction

    function automatic logic [31:0] a_val(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h0000_0005;
            4: return 32'h0000_0064;
            5: return 32'h7FFF_FFFF;
            6: return 32'h8000_0000;
            7: return 32'h0000_8000;
            default: return 32'hFFFF_8000;
        endcase
    endfunction

    function automatic logic [15:0] i_val(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h0005;
            4: return 16'h8000;
            5: return 16'h7FFF;
            default: return 16'h0064;
        endcase
    endfunction

    // cycle lengths of the retiring instructions, in order
    function automatic int gap(input int k);
        case (k)
            2: return 6;          // compare
            1, 4: return 4;       // subtract, AND
            5: return 6;          // unknown (2) + subtract (4)
            default: return 5;    // loads and stores
        endcase
    endfunction

    function automatic int last_step(input int k);
        case (k)
            2: return 5;
            1, 4, 5: return 3;
            default: return 4;
        endcase
    endfunction

    task automatic run_case(input logic [31:0] av, input logic [15:0] iv);
        logic [31:0] bv, sx, dif, sgt;
        int rt [13];
        int nret;
        int cyc;
        bv  = {av[15:0], av[31:16]} ^ 32'hF0F0_1234;
        sx  = {{16{iv[15]}}, iv};
        dif = av - sx;
        sgt = (!dif[31] && dif != 0) ? 32'd1 : 32'd0;

        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        mem[0]  = enc(6'h23, 5'd0, 5'd1, 16'h0040);
        mem[1]  = enc(6'h0A, 5'd1, 5'd2, iv);
        mem[2]  = enc(6'h0B, 5'd1, 5'd3, iv);
        mem[3]  = enc(6'h23, 5'd0, 5'd4, 16'h0041);
        mem[4]  = enc(6'h24, 5'd1, 5'd5, {5'd4, 11'd0});
        mem[5]  = 32'hFC00_0000;
        mem[6]  = enc(6'h0A, 5'd1, 5'd0, iv);
        mem[7]  = enc(6'h2B, 5'd0, 5'd2, 16'h0050);
        mem[8]  = enc(6'h2B, 5'd0, 5'd3, 16'h0051);
        mem[9]  = enc(6'h2B, 5'd0, 5'd5, 16'h0052);
        mem[10] = enc(6'h2B, 5'd0, 5'd0, 16'h0053);
        mem[11] = enc(6'h23, 5'd0, 5'd7, 16'h0042);
        mem[12] = enc(6'h2B, 5'd7, 5'd2, 16'hFFFF);
        mem[13] = enc(6'h2B, 5'd7, 5'd1, 16'h0010);
        mem[8'h40] = av;
        mem[8'h41] = bv;
        mem[8'h42] = 32'h0000_0060;
        mem[8'h53] = 32'h0000_DEAD;
        @(negedge clk);
        // R1: reset state
        check("R1 step", {29'd0, step}, 32'd0);
        check("R1 addr", {16'd0, mem_addr}, 32'd0);
        check("R1 we/retire", {30'd0, mem_we, retire}, 32'd0);
        rst_n = 1'b1;

        nret = 0;
        cyc  = 0;
        check("R9 fetch step", {29'd0, step}, 32'd0);
        while (nret < 13 && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (retire) begin
                rt[nret] = cyc;
                check("R9 retire step", {29'd0, step}, 32'(last_step(nret)));
                nret++;
            end
        end
        if (nret < 13) begin
            check("R9 retire count", 32'(nret), 32'd13);
            return;
        end
        @(negedge clk);

        check("R2 first load length", 32'(rt[0]), 32'd4);
        for (int k = 1; k < 13; k++)
            check((k == 5) ? "R8 unknown + R5 gap" :
                  (k == 2) ? "R6 length" :
                  (k == 1 || k == 4) ? "R4/R5 length" : "R2/R3 length",
                  32'(rt[k] - rt[k-1]), 32'(gap(k)));

        check("R5 subtract", mem[8'h50], dif);
        check("R6 compare flag", mem[8'h51], sgt);
        check("R4 and", mem[8'h52], av & bv);
        check("R7 r0 store", mem[8'h53], 32'd0);
        check("R3 negative offset store", mem[8'h5F], dif);
        check("R2 load via base", mem[8'h70], av);
        check("R8 no stray write", mem[8'h54], 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        for (int ai = 0; ai < 9; ai++)
            for (int ii = 0; ii < 7; ii++)
                run_case(a_val(ai), i_val(ii));
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule